// File: doc/BRIEF.md
# Pulse Arrival Delay Tracking Controller

This block steers an 8-bit delay code for an external programmable delay element so that a once-per-second reference pulse, after it passes through that element, lines up with a locally generated one-second tick. The local tick comes from a free-running divider on the system clock. The divider is never stretched or shortened, so the local timebase is never disturbed to force alignment.

On every delayed reference pulse the block measures the phase of the local divider at the moment the pulse arrives. A pulse that arrives after the tick is late, and the code moves up by one. A pulse that arrives before the next tick is early, and the code moves down by one. The code starts at mid-scale (128) and saturates at both ends. One step is about 16 ns, and the full range is about ±2 µs.

A fixed mode holds the code at a supplied constant, for use during initial acquisition. Each pulse also produces a one-cycle sample strobe that carries the code in force for that pulse, for downstream accumulation. An out-of-range flag reports when the code has drifted about 1 µs (62 codes) or more from mid-scale.

Top module: `pulse_align_tracker`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, code_o is 128, sample_valid_o is 0 and out_of_range_o is 0.
- R2: In variable mode (mode_var_i = 1), a pulse_i seen at divider phase p changes code_o one cycle later: by +1 for 1 <= p <= DIV/2 (late), by -1 for DIV/2 < p <= DIV-1 (early), and by 0 for p = 0. Phase p is the number of cycles since the last tick_o cycle, and it is 0 in the tick cycle itself.
- R3: The code saturates. A late pulse at code 255 leaves it at 255, and an early pulse at code 0 leaves it at 0. There is no wraparound.
- R4: In variable mode, a cycle without pulse_i leaves code_o unchanged in the next cycle.
- R5: In fixed mode (mode_var_i = 0), code_o equals fixed_code_i as sampled one cycle earlier, and pulses do not move it. When the mode returns to variable, tracking resumes from the code held at that point.
- R6: out_of_range_o is 1 exactly when code_o <= 66 or code_o >= 190, that is, when the code is 62 or more away from 128.
- R7: One cycle after each pulse_i, sample_valid_o is high for exactly one cycle. At the same time sample_code_o shows the code that was in force when the pulse arrived, before any update.
- R8: tick_o is high for one cycle every DIV cycles. It is high first in the first cycle after reset release, and pulse_i never changes its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_var_i | input | 1 | 1 = variable tracking, 0 = fixed code |
| fixed_code_i | input | 8 | Code held in fixed mode |
| pulse_i | input | 1 | Delayed reference pulse, one-cycle synchronous strobe |
| code_o | output | 8 | Current delay code to the delay element |
| sample_valid_o | output | 1 | One-cycle strobe after each pulse |
| sample_code_o | output | 8 | Code in force for the pulse just seen |
| out_of_range_o | output | 1 | Code is 62 or more away from mid-scale |
| tick_o | output | 1 | Local once-per-period tick |

## Verification
The bench sweeps every divider phase with DIV = 16. A wrong boundary between late and early, or a step taken on the aligned phase, shows up as a code off by one or two at the phase concerned. It drives the code into both rails and holds it there: a design that wraps jumps to the opposite extreme. Every step along those ramps is compared against the 66/190 thresholds, so a window that is off by one code flags too early or too late. Fixed mode is checked with pulses present and across a return to variable mode, which exposes a stepper that reloads to mid-scale. The tick spacing is measured while pulses are applied, which catches a divider that a pulse restarts.

// File: rtl/pat_pkg.sv
package pat_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/pat_tick_gen.sv
module pat_tick_gen #(
  parameter int unsigned DIV   = 10_000_000,
  parameter int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] phase_o,
  output logic             tick_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  // free-running; never adjusted by the tracking loop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign phase_o = cnt_q;
  assign tick_o  = (cnt_q == '0);

  generate
    if (DIV > 1) begin : g_tick_chk
      a_r8_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
      a_r8_wrap_to_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == LAST) |=> tick_o);
    end
  endgenerate
endmodule

// File: rtl/pat_phase_det.sv
module pat_phase_det
  import pat_pkg::*;
#(
  parameter int unsigned DIV   = 10_000_000,
  parameter int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic [CNT_W-1:0] phase_i,
  output step_e            step_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DIV / 2);

  // pulse after tick -> late -> more delay; before next tick -> early
  always_comb begin
    if (phase_i == '0)        step_o = STEP_HOLD;
    else if (phase_i <= HALF) step_o = STEP_UP;
    else                      step_o = STEP_DOWN;
  end
endmodule

// File: rtl/pat_code_stepper.sv
module pat_code_stepper
  import pat_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_var_i,
  input  logic [CODE_W-1:0] fixed_code_i,
  input  logic              pulse_i,
  input  step_e             step_i,
  output logic [CODE_W-1:0] code_o,
  output logic              sample_valid_o,
  output logic [CODE_W-1:0] sample_code_o
);
  localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CMAX = '1;

  logic [CODE_W-1:0] code_q, code_d;
  logic              sv_q;
  logic [CODE_W-1:0] sc_q;

  always_comb begin
    code_d = code_q;
    if (!mode_var_i) begin
      code_d = fixed_code_i;
    end else if (pulse_i) begin
      unique case (step_i)
        STEP_UP:   if (code_q != CMAX) code_d = code_q + 1'b1;
        STEP_DOWN: if (code_q != '0)   code_d = code_q - 1'b1;
        default:   code_d = code_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= MID;
      sv_q   <= 1'b0;
      sc_q   <= MID;
    end else begin
      code_q <= code_d;
      sv_q   <= pulse_i;
      if (pulse_i) sc_q <= code_q;
    end
  end

  assign code_o         = code_q;
  assign sample_valid_o = sv_q;
  assign sample_code_o  = sc_q;

  a_r2_max_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_var_i && pulse_i) |=>
      ((code_q == $past(code_q)) || (code_q == $past(code_q) + 1'b1) ||
       (code_q == $past(code_q) - 1'b1)));
  a_r3_no_wrap_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_var_i && pulse_i && code_q == CMAX) |=> (code_q != '0));
  a_r3_no_wrap_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_var_i && pulse_i && code_q == '0) |=> (code_q != CMAX));
  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_var_i && !pulse_i) |=> $stable(code_q));
  a_r5_fixed_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_var_i |=> (code_q == $past(fixed_code_i)));
  a_r7_sample_old_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> (sample_valid_o && sample_code_o == $past(code_q)));
  a_r7_strobe_only_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> !sample_valid_o);
endmodule

// File: rtl/pat_range_mon.sv
module pat_range_mon #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned WIN    = 62
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              out_of_range_o
);
  localparam int unsigned MID_I = 1 << (CODE_W - 1);
  localparam logic [CODE_W-1:0] HI = CODE_W'(MID_I + WIN);
  localparam logic [CODE_W-1:0] LO = CODE_W'(MID_I - WIN);

  assign out_of_range_o = (code_i >= HI) || (code_i <= LO);
endmodule

// File: rtl/pulse_align_tracker.sv
module pulse_align_tracker
  import pat_pkg::*;
#(
  parameter int unsigned DIV    = 10_000_000,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned WIN    = 62
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_var_i,
  input  logic [CODE_W-1:0] fixed_code_i,
  input  logic              pulse_i,
  output logic [CODE_W-1:0] code_o,
  output logic              sample_valid_o,
  output logic [CODE_W-1:0] sample_code_o,
  output logic              out_of_range_o,
  output logic              tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] phase;
  step_e            step;

  pat_tick_gen #(.DIV(DIV), .CNT_W(CNT_W)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .tick_o  (tick_o)
  );

  pat_phase_det #(.DIV(DIV), .CNT_W(CNT_W)) u_det (
    .phase_i (phase),
    .step_o  (step)
  );

  pat_code_stepper #(.CODE_W(CODE_W)) u_step (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_var_i     (mode_var_i),
    .fixed_code_i   (fixed_code_i),
    .pulse_i        (pulse_i),
    .step_i         (step),
    .code_o         (code_o),
    .sample_valid_o (sample_valid_o),
    .sample_code_o  (sample_code_o)
  );

  pat_range_mon #(.CODE_W(CODE_W), .WIN(WIN)) u_range (
    .code_i         (code_o),
    .out_of_range_o (out_of_range_o)
  );

  a_r8_tick_ignores_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !tick_o && phase != CNT_W'(DIV - 1)) |=> !tick_o);
endmodule

// File: tb/pulse_align_tracker_tb.sv
module pulse_align_tracker_tb;
  localparam int DIV  = 16;
  localparam int HALF = DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_var = 1'b1;
  logic [7:0] fixed_code = 8'd0;
  logic       pulse = 1'b0;
  logic [7:0] code, s_code;
  logic       s_valid, oor, tick;

  int checks = 0;
  int errors = 0;
  int exp_code = 128;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_align_tracker #(.DIV(DIV), .CODE_W(8), .WIN(62)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_var_i(mode_var),
    .fixed_code_i(fixed_code), .pulse_i(pulse), .code_o(code),
    .sample_valid_o(s_valid), .sample_code_o(s_code),
    .out_of_range_o(oor), .tick_o(tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_oor(input int c);
    return ((c <= 66) || (c >= 190)) ? 1 : 0;
  endfunction

  // pulse at phase p, then check code, sample strobe, range flag (R2 R6 R7)
  task automatic pulse_at(input int p);
    int prev;
    do @(negedge clk); while (!tick);
    repeat (p) @(negedge clk);
    prev = exp_code;
    pulse = 1'b1;
    @(negedge clk);
    pulse = 1'b0;
    if (mode_var) begin
      if (p == 0)         exp_code = prev;
      else if (p <= HALF) exp_code = (prev == 255) ? 255 : prev + 1;
      else                exp_code = (prev == 0) ? 0 : prev - 1;
    end
    chk("R2/R3 code after pulse", code, exp_code);
    chk("R7 sample valid", s_valid, 1);
    chk("R7 sample code", s_code, prev);
    chk("R6 range flag", oor, exp_oor(exp_code));
    @(negedge clk);
    chk("R7 strobe one cycle", s_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset code", code, 128);
    chk("R1 reset valid", s_valid, 0);
    chk("R1 reset range", oor, 0);
    rst_n = 1'b1;
    chk("R1 code after release", code, 128);
    chk("R8 first tick", tick, 1);

    // R2: every phase
    for (int p = 0; p < DIV; p++) pulse_at(p);

    // R4: idle period keeps code
    repeat (2 * DIV) @(negedge clk);
    chk("R4 idle hold", code, exp_code);

    // R3/R6: ramp up to the rail and beyond
    for (int i = 0; i < 140; i++) pulse_at(1 + (i % HALF));
    chk("R3 high rail", code, 255);
    // ramp down through the whole range
    for (int i = 0; i < 270; i++) pulse_at(HALF + 1 + (i % (DIV - HALF - 1)));
    chk("R3 low rail", code, 0);

    // R5: fixed mode
    @(negedge clk);
    mode_var = 1'b0;
    fixed_code = 8'd200;
    @(negedge clk);
    chk("R5 fixed load", code, 200);
    chk("R6 fixed 200 flag", oor, 1);
    exp_code = 200;
    pulse_at(3);
    pulse_at(12);
    chk("R5 fixed ignores pulse", code, 200);
    fixed_code = 8'd100;
    @(negedge clk);
    chk("R5 fixed reload", code, 100);
    chk("R6 fixed 100 flag", oor, 0);
    exp_code = 100;
    mode_var = 1'b1;
    fixed_code = 8'd7;
    @(negedge clk);
    chk("R5 resume from held", code, 100);
    pulse_at(5);
    chk("R5 tracking resumes", code, 101);

    // R6 boundaries via fixed mode
    for (int c = 64; c <= 68; c++) begin
      mode_var = 1'b0; fixed_code = 8'(c);
      @(negedge clk);
      chk("R6 low edge", oor, exp_oor(c));
    end
    for (int c = 188; c <= 192; c++) begin
      fixed_code = 8'(c);
      @(negedge clk);
      chk("R6 high edge", oor, exp_oor(c));
    end
    mode_var = 1'b1;

    // R8: tick spacing with pulses injected mid-period
    do @(negedge clk); while (!tick);
    for (int k = 0; k < 4; k++) begin
      int gap;
      gap = 0;
      do begin
        pulse = (gap == 5);
        @(negedge clk);
        gap++;
      end while (!tick);
      pulse = 1'b0;
      chk("R8 tick period", gap, DIV);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule